// File: doc/BRIEF.md
# I2C Slave Bus Status Monitor

This block listens passively to an I2C bus whose SCL and SDA lines have already been filtered and brought into the local clock domain. It finds start, repeated start and stop conditions by the way SDA moves while SCL is high. It shifts in the first byte after each start and compares the upper seven bits with a programmable own address. It also checks whether the whole byte is the general call code.

From these events it keeps a small set of status flags: bus busy, repeated start seen, own address matched, general call matched, first byte in progress, transfer direction and the last acknowledge bit. An interrupt request is raised when the block is addressed and a byte finishes, or when a repeated start arrives. A one-cycle clear strobe drops the interrupt and the repeated-start flag. The block never drives the bus. A surrounding slave controller uses the flags to decide when to take part in a transfer.

Top module: `i2c_bus_status_mon`

## Requirements
- R1: SDA falling while SCL stays high, with the bus idle, sets busy and first-byte, and clears addressed and general call.
- R2: SDA rising while SCL stays high (a stop) clears busy, addressed, general call and first-byte.
- R3: A start seen while busy is a repeated start. It sets the repeated-start flag and the interrupt, sets first-byte again and clears addressed and general call until the new address is compared.
- R4: Data bits are sampled on SCL rising edges, MSB first. On the eighth rising edge of the first byte, addressed becomes 1 exactly when bits 7..1 of that byte equal the own address.
- R5: On the eighth rising edge of the first byte, general call becomes 1 exactly when all eight bits are 0.
- R6: On the eighth rising edge of the first byte, the direction flag takes bit 0 of that byte (1 = read, 0 = write). Later bytes leave direction, addressed and general call unchanged.
- R7: On the ninth SCL rising edge of every byte, the SDA value is stored as the acknowledge flag (0 = acknowledged).
- R8: First-byte drops to 0 on the ninth SCL rising edge of the first byte. It stays 0 until the next start.
- R9: The interrupt is set on the ninth SCL rising edge of any byte while addressed or general call is 1, and on a repeated start. The clear strobe resets the interrupt and the repeated-start flag.
- R10: SCL clocking while the bus is idle does no shifting and no address compare, and it sets no flag.
- R11: After reset all outputs are 0.
- R12: A line change presented to the inputs shows on the flags after the second rising clock edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Filtered, synchronised SCL level |
| sda_i | input | 1 | Filtered, synchronised SDA level |
| own_addr_i | input | 7 | Own slave address |
| clr_i | input | 1 | Clears the interrupt and the repeated-start flag |
| busy_o | output | 1 | Bus between a start and a stop |
| rep_start_o | output | 1 | Repeated start seen since last clear |
| addressed_o | output | 1 | Own address matched in the current first byte |
| gen_call_o | output | 1 | General call matched in the current first byte |
| first_byte_o | output | 1 | First byte after a start in progress |
| dir_o | output | 1 | R/W bit of the last first byte |
| ack_o | output | 1 | SDA level on the last ninth clock |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong bit counter shifts the address compare by one bit. That shows as a wrong addressed, general call or direction flag within two clock cycles of the eighth SCL rise, or as an acknowledge or first-byte flag that changes on the wrong clock. A wrong bus-busy state shows as a missing repeated-start flag or a missing interrupt at the next start. Stuck flags show at the next stop, which must clear them two cycles after SDA rises.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  // one-cycle line events derived from the sampled bus
  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
  } line_ev_t;

endpackage

// File: rtl/i2cm_rst_sync.sv
module i2cm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/i2cm_line_events.sv
module i2cm_line_events
  import i2cm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output logic     sda_s,
  output line_ev_t ev
);

  logic scl_s, scl_p, sda_p;
  logic scl_s_d, sda_s_d, scl_p_d, sda_p_d;

  always_comb begin
    scl_s_d = scl_i;
    sda_s_d = sda_i;
    scl_p_d = scl_s;
    sda_p_d = sda_s;
  end

  // idle bus is high on both lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 1'b1;
      sda_s <= 1'b1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_s <= scl_s_d;
      sda_s <= sda_s_d;
      scl_p <= scl_p_d;
      sda_p <= sda_p_d;
    end
  end

  always_comb begin
    ev.start    = scl_p & scl_s & sda_p & ~sda_s;
    ev.stop     = scl_p & scl_s & ~sda_p & sda_s;
    ev.scl_rise = ~scl_p & scl_s;
  end

endmodule

// File: rtl/i2cm_shifter.sv
module i2cm_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              active,
  input  logic              scl_rise,
  input  logic              sda,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              ack_stb,
  output logic              ack_bit
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] ACK_POS  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-2:0] sh_q, sh_d;
  logic              clk_en;

  assign clk_en = restart | (active & scl_rise);

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (restart) begin
      cnt_d = '0;
    end else if (cnt_q == ACK_POS) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
      sh_d  = {sh_q[BYTE_W-3:0], sda};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clk_en) begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign byte_val  = {sh_q, sda};
  assign byte_done = active & scl_rise & ~restart & (cnt_q == LAST_POS);
  assign ack_stb   = active & scl_rise & ~restart & (cnt_q == ACK_POS);
  assign ack_bit   = sda;

endmodule

// File: rtl/i2cm_addr_cmp.sv
module i2cm_addr_cmp #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W:0]   rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              own_hit,
  output logic              gc_hit
);

  logic [ADDR_W-1:0] bit_eq;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_eq
    assign bit_eq[i] = rx_byte[i+1] ~^ own_addr[i];
  end

  assign own_hit = &bit_eq;
  assign gc_hit  = ~|rx_byte;

endmodule

// File: rtl/i2c_bus_status_mon.sv
module i2c_bus_status_mon
  import i2cm_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              clr_i,
  output logic              busy_o,
  output logic              rep_start_o,
  output logic              addressed_o,
  output logic              gen_call_o,
  output logic              first_byte_o,
  output logic              dir_o,
  output logic              ack_o,
  output logic              irq_o
);

  localparam int BYTE_W = ADDR_W + 1;

  logic              rst_q_n;
  logic              sda_s;
  line_ev_t          ev;
  logic              start_ev, stop_ev, rise_ev;
  logic              byte_done, ack_stb, ack_bit;
  logic [BYTE_W-1:0] byte_val;
  logic              own_hit, gc_hit;

  logic busy_q, rsc_q, addr_q, gc_q, first_q, dir_q, ack_q, irq_q;
  logic busy_d, rsc_d, addr_d, gc_d, first_d, dir_d, ack_d, irq_d;

  i2cm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  i2cm_line_events u_lev (
    .clk(clk), .rst_n(rst_q_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .ev(ev)
  );

  assign start_ev = ev.start;
  assign stop_ev  = ev.stop;
  assign rise_ev  = ev.scl_rise;

  i2cm_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_q_n),
    .restart(start_ev | stop_ev), .active(busy_q),
    .scl_rise(rise_ev), .sda(sda_s),
    .byte_done(byte_done), .byte_val(byte_val),
    .ack_stb(ack_stb), .ack_bit(ack_bit)
  );

  i2cm_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .rx_byte(byte_val), .own_addr(own_addr_i),
    .own_hit(own_hit), .gc_hit(gc_hit)
  );

  // next-state for the status set
  always_comb begin
    busy_d  = busy_q;
    rsc_d   = rsc_q;
    addr_d  = addr_q;
    gc_d    = gc_q;
    first_d = first_q;
    dir_d   = dir_q;
    ack_d   = ack_q;
    irq_d   = irq_q;

    if (start_ev) begin
      busy_d  = 1'b1;
      first_d = 1'b1;
      addr_d  = 1'b0;
      gc_d    = 1'b0;
    end else if (stop_ev) begin
      busy_d  = 1'b0;
      first_d = 1'b0;
      addr_d  = 1'b0;
      gc_d    = 1'b0;
    end else begin
      if (byte_done && first_q) begin
        addr_d = own_hit;
        gc_d   = gc_hit;
        dir_d  = byte_val[0];
      end
      if (ack_stb) begin
        ack_d   = ack_bit;
        first_d = 1'b0;
      end
    end

    if (clr_i) begin
      rsc_d = 1'b0;
      irq_d = 1'b0;
    end
    if (start_ev && busy_q) begin
      rsc_d = 1'b1;
      irq_d = 1'b1;
    end
    if (ack_stb && (addr_q || gc_q)) begin
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      busy_q  <= 1'b0;
      rsc_q   <= 1'b0;
      addr_q  <= 1'b0;
      gc_q    <= 1'b0;
      first_q <= 1'b0;
      dir_q   <= 1'b0;
      ack_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      rsc_q   <= rsc_d;
      addr_q  <= addr_d;
      gc_q    <= gc_d;
      first_q <= first_d;
      dir_q   <= dir_d;
      ack_q   <= ack_d;
      irq_q   <= irq_d;
    end
  end

  assign busy_o       = busy_q;
  assign rep_start_o  = rsc_q;
  assign addressed_o  = addr_q;
  assign gen_call_o   = gc_q;
  assign first_byte_o = first_q;
  assign dir_o        = dir_q;
  assign ack_o        = ack_q;
  assign irq_o        = irq_q;

endmodule

// File: rtl/i2cm_status_chk.sv
module i2cm_status_chk (
  input logic clk,
  input logic rst_q_n,
  input logic start_ev,
  input logic stop_ev,
  input logic ack_stb,
  input logic busy_o,
  input logic rep_start_o,
  input logic addressed_o,
  input logic gen_call_o,
  input logic first_byte_o,
  input logic dir_o,
  input logic irq_o
);

  // R1: a start opens a fresh address phase
  p_start_opens_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    start_ev |=> (busy_o && first_byte_o && !addressed_o && !gen_call_o));

  // R2: a stop drops the transfer flags
  p_stop_clears_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    stop_ev |=> (!busy_o && !first_byte_o && !addressed_o && !gen_call_o));

  // R3: start while busy marks a repeated start and interrupts
  p_rep_start_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start_ev && busy_o) |=> (rep_start_o && irq_o));

  // R5/R6: general call is a write address
  p_gcall_write_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    gen_call_o |-> !dir_o);

  // R10: no address flags outside a transfer
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !busy_o |-> (!addressed_o && !gen_call_o && !first_byte_o));

  // R9: a completed byte while addressed requests an interrupt
  p_irq_on_byte_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ack_stb && (addressed_o || gen_call_o)) |=> irq_o);

endmodule

bind i2c_bus_status_mon i2cm_status_chk u_chk (
  .clk(clk), .rst_q_n(rst_q_n),
  .start_ev(start_ev), .stop_ev(stop_ev), .ack_stb(ack_stb),
  .busy_o(busy_o), .rep_start_o(rep_start_o), .addressed_o(addressed_o),
  .gen_call_o(gen_call_o), .first_byte_o(first_byte_o), .dir_o(dir_o),
  .irq_o(irq_o)
);

// File: tb/sim_i2c_bus_status_mon.sv
`timescale 1ns/1ps
module sim_i2c_bus_status_mon;

  localparam int PH = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl, sda, clr;
  logic [6:0] own;
  logic busy, rsc, addr, gc, first, dir, ack, irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_bus_status_mon u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .own_addr_i(own), .clr_i(clr),
    .busy_o(busy), .rep_start_o(rsc), .addressed_o(addr),
    .gen_call_o(gc), .first_byte_o(first), .dir_o(dir),
    .ack_o(ack), .irq_o(irq)
  );

  function automatic logic f_hit(input logic [7:0] b, input logic [6:0] a);
    return b[7:1] == a;
  endfunction
  function automatic logic f_gc(input logic [7:0] b);
    return b == 8'h00;
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic ph();
    repeat (PH) @(negedge clk);
  endtask

  task automatic do_start();      // from idle: scl=1, sda=1
    sda = 1'b0; ph();
    scl = 1'b0; ph();
  endtask

  task automatic do_rstart();     // scl low on entry
    sda = 1'b1; ph();
    scl = 1'b1; ph();
    sda = 1'b0; ph();
    scl = 1'b0; ph();
  endtask

  task automatic do_stop();       // scl low on entry
    sda = 1'b0; ph();
    scl = 1'b1; ph();
    sda = 1'b1; ph();
  endtask

  task automatic do_bit(input logic b);
    sda = b;    ph();
    scl = 1'b1; ph();
    scl = 1'b0; ph();
  endtask

  task automatic do_bits8(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) do_bit(b[i]);
  endtask

  task automatic pulse_clr();
    clr = 1'b1; @(negedge clk);
    clr = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic       a, bus_on, eh, eg, ed;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1; clr = 1'b0; own = 7'h2A;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk(busy, 0, "R11 busy"); chk(rsc, 0, "R11 rsc"); chk(addr, 0, "R11 addr");
    chk(gc, 0, "R11 gc"); chk(first, 0, "R11 first"); chk(dir, 0, "R11 dir");
    chk(ack, 0, "R11 ack"); chk(irq, 0, "R11 irq");

    // R10 idle clocking with own address pattern
    scl = 1'b0; ph();
    do_bits8({7'h2A, 1'b1}); do_bit(1'b0);
    sda = 1'b1; ph(); scl = 1'b1; ph();
    chk(addr, 0, "R10 addr idle"); chk(first, 0, "R10 first idle");
    chk(irq, 0, "R10 irq idle"); chk(busy, 0, "R10 busy idle");

    // R12 latency of a start
    sda = 1'b0;
    @(negedge clk); chk(busy, 0, "R12 one edge");
    @(negedge clk); chk(busy, 1, "R12 two edges");
    ph(); scl = 1'b0; ph();
    chk(first, 1, "R1 first"); chk(addr, 0, "R1 addr");

    // R4 R6 read address hit
    do_bits8({7'h2A, 1'b1});
    chk(addr, 1, "R4 hit"); chk(dir, 1, "R6 read"); chk(gc, 0, "R5 no gc");
    chk(first, 1, "R8 before ack");
    do_bit(1'b0);
    chk(first, 0, "R8 after ack"); chk(ack, 0, "R7 ack0"); chk(irq, 1, "R9 irq");
    pulse_clr(); chk(irq, 0, "R9 clr");
    // data byte 0x00 must not recompare
    do_bits8(8'h00); do_bit(1'b1);
    chk(addr, 1, "R6 data keeps addr"); chk(gc, 0, "R6 data no gc");
    chk(dir, 1, "R6 data keeps dir"); chk(ack, 1, "R7 ack1"); chk(irq, 1, "R9 data irq");
    pulse_clr();
    do_rstart();
    chk(rsc, 1, "R3 rsc"); chk(irq, 1, "R3 irq"); chk(first, 1, "R3 first");
    chk(addr, 0, "R3 addr cleared");
    pulse_clr(); chk(rsc, 0, "R9 rsc clr");
    do_bits8(8'h00);
    chk(gc, 1, "R5 gc"); chk(addr, 0, "R5 addr"); chk(dir, 0, "R6 write");
    do_bit(1'b0); chk(irq, 1, "R9 gc irq");
    do_stop();
    chk(busy, 0, "R2 busy"); chk(addr, 0, "R2 addr"); chk(gc, 0, "R2 gc");
    chk(first, 0, "R2 first");
    pulse_clr();

    // random transactions
    bus_on = 1'b0;
    for (int t = 0; t < 40; t++) begin
      own = 7'($urandom);
      case ($urandom % 4)
        0: b = {own, 1'($urandom)};
        1: b = 8'h00;
        default: b = 8'($urandom);
      endcase
      eh = f_hit(b, own); eg = f_gc(b); ed = b[0];
      pulse_clr();
      if (bus_on) begin
        do_rstart(); chk(rsc, 1, "R3 rand rsc"); pulse_clr();
      end else begin
        do_start(); chk(busy, 1, "R1 rand busy");
      end
      chk(first, 1, "R1 rand first");
      do_bits8(b);
      chk(addr, eh, "R4 rand hit"); chk(gc, eg, "R5 rand gc");
      chk(dir, ed, "R6 rand dir");
      a = 1'($urandom);
      do_bit(a);
      chk(ack, a, "R7 rand ack"); chk(first, 0, "R8 rand first");
      chk(irq, eh | eg, "R9 rand irq");
      for (int k = 0; k < int'($urandom % 3); k++) begin
        do_bits8(8'($urandom)); a = 1'($urandom); do_bit(a);
        chk(ack, a, "R7 rand data ack"); chk(addr, eh, "R6 rand data addr");
        chk(dir, ed, "R6 rand data dir");
      end
      if ($urandom % 2) begin
        do_stop(); bus_on = 1'b0;
        chk(busy, 0, "R2 rand busy"); chk(addr, 0, "R2 rand addr");
        chk(gc, 0, "R2 rand gc");
      end else begin
        bus_on = 1'b1;
      end
    end
    if (bus_on) begin
      do_stop(); chk(busy, 0, "R2 final busy");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule